// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block chooses which of several DMA channels is served next. Each channel presents three inputs: a request line, an enable bit and a 2-bit priority code. A channel takes part in arbitration only when its request line and its enable bit are both high. Among those channels, the one with the highest priority code wins. When several share that code, the one with the lowest index wins.

The choice is registered. A grant, once issued, stays in place until the transfer in progress raises a completion strobe. The block then evaluates the inputs again. A higher-priority request arriving mid-transfer therefore never takes the bus away from the current channel.

Alongside the one-hot grant, the block drives three more outputs: the binary index of the winner, a valid flag, and the winner's priority code. The priority code is forwarded as the priority of the system-bus reads and writes issued for that channel. The channel count is a parameter with a default of four.

Top module: `dma_chan_arbiter`

## Requirements
- R1: While reset is asserted, `grantVec`, `grantIdx` and `busPrio` are zero and `grantValid` is low.
- R2: A channel takes part only if both its `chReq` bit and its `chEn` bit are 1. A request with a clear enable bit is never granted.
- R3: Priority codes order as 2'b00 < 2'b01 < 2'b10 < 2'b11, where 2'b11 is the highest. The winner's code is the largest code among the participants.
- R4: Among participants that share the largest code, the channel with the lowest index is granted, for any channel count.
- R5: `busPrio` equals the granted channel's code, sampled in the evaluation cycle. Channel i's code is `chPrio[2*i+1:2*i]`.
- R6: An evaluation takes place on every clock edge where `grantValid` is low or `xferDone` is high. Its result appears on the outputs one clock later.
- R7: While `grantValid` is high and `xferDone` is low, `grantVec`, `grantIdx` and `busPrio` hold, whatever the inputs do.
- R8: If no channel participates at an evaluation, the next outputs are all zero and `grantValid` is low.
- R9: `grantVec` is zero or has exactly one bit set. When valid, that bit is bit `grantIdx`, and `grantValid` equals the OR of `grantVec`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chReq | input | NUM_CH | Request line per channel |
| chEn | input | NUM_CH | Enable bit per channel |
| chPrio | input | NUM_CH*PRIO_W | Packed priority codes, channel i at bits [PRIO_W*i +: PRIO_W] |
| xferDone | input | 1 | Current transfer completes this cycle |
| grantVec | output | NUM_CH | One-hot grant |
| grantIdx | output | IDX_W | Encoded granted channel |
| grantValid | output | 1 | A grant is held |
| busPrio | output | PRIO_W | Granted channel's code, forwarded as bus transaction priority |

## Verification
The selection logic is tried against several input patterns:
- Single participants show that the request and enable lines are decoded per channel.
- Requests with enable clear, and enables without a request, separate the two qualifying inputs.
- Pairs with different codes exercise the code ordering.
- Groups sharing the top code, with lower channels absent or disabled, exercise the lowest-index tie-break.
- Two further stimulus sets cover all combinations of codes with every channel participating, and a pseudo-random set of request, enable and code patterns.

Transfers are also held across changing inputs with the completion strobe low, which tells a held grant apart from one that is re-evaluated every cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic evalNow;   // capture a fresh selection this cycle
    logic dropAll;   // evaluation found no participant
  } arbStrobe_t;

endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic       grantValid,
  input  logic       xferDone,
  input  logic       anyElig,
  output arbStrobe_t strobe
);

  // A held grant is released only by the completion strobe; an idle
  // arbiter evaluates on every edge.
  logic openWindow;

  always_comb begin
    openWindow     = !grantValid || xferDone;
    strobe.evalNow = openWindow;
    strobe.dropAll = openWindow && !anyElig;
  end

endmodule

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PRIO_W = 2,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        chReq,
  input  logic [NUM_CH-1:0]        chEn,
  input  logic [NUM_CH*PRIO_W-1:0] chPrio,
  input  arbStrobe_t               strobe,
  output logic                     anyElig,
  output logic [NUM_CH-1:0]        grantVec,
  output logic [IDX_W-1:0]         grantIdx,
  output logic                     grantValid,
  output logic [PRIO_W-1:0]        busPrio
);

  logic [NUM_CH-1:0] elig;
  logic [PRIO_W-1:0] codeOf [NUM_CH];

  // Per-channel qualification and code extraction
  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    assign elig[g]   = chReq[g] & chEn[g];
    assign codeOf[g] = chPrio[g*PRIO_W +: PRIO_W];
  end

  assign anyElig = |elig;

  // Linear scan: strict greater-than keeps the earlier (lower) index on a tie
  logic              pickFound;
  logic [IDX_W-1:0]  pickIdx;
  logic [PRIO_W-1:0] pickCode;
  logic [NUM_CH-1:0] pickVec;

  always_comb begin
    pickFound = 1'b0;
    pickIdx   = '0;
    pickCode  = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (elig[i] && (!pickFound || (codeOf[i] > pickCode))) begin
        pickFound = 1'b1;
        pickIdx   = IDX_W'(i);
        pickCode  = codeOf[i];
      end
    end
    pickVec = '0;
    if (pickFound) pickVec[pickIdx] = 1'b1;
  end

  // Held grant registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grantVec   <= '0;
      grantIdx   <= '0;
      grantValid <= 1'b0;
      busPrio    <= '0;
    end else if (strobe.dropAll) begin
      grantVec   <= '0;
      grantIdx   <= '0;
      grantValid <= 1'b0;
      busPrio    <= '0;
    end else if (strobe.evalNow) begin
      grantVec   <= pickVec;
      grantIdx   <= pickIdx;
      grantValid <= pickFound;
      busPrio    <= pickCode;
    end
  end

endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int PRIO_W = 2,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        chReq,
  input  logic [NUM_CH-1:0]        chEn,
  input  logic [NUM_CH*PRIO_W-1:0] chPrio,
  input  logic                     xferDone,
  output logic [NUM_CH-1:0]        grantVec,
  output logic [IDX_W-1:0]         grantIdx,
  output logic                     grantValid,
  output logic [PRIO_W-1:0]        busPrio
);

  arbStrobe_t strobe;
  logic       anyElig;

  dma_arb_ctrl u_ctrl (
    .grantValid (grantValid),
    .xferDone   (xferDone),
    .anyElig    (anyElig),
    .strobe     (strobe)
  );

  dma_arb_datapath #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .chReq      (chReq),
    .chEn       (chEn),
    .chPrio     (chPrio),
    .strobe     (strobe),
    .anyElig    (anyElig),
    .grantVec   (grantVec),
    .grantIdx   (grantIdx),
    .grantValid (grantValid),
    .busPrio    (busPrio)
  );

endmodule

// File: rtl/dma_chan_arbiter_chk.sv
module dma_chan_arbiter_chk #(
  parameter int NUM_CH = 4,
  parameter int PRIO_W = 2,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CH-1:0]        chReq,
  input logic [NUM_CH-1:0]        chEn,
  input logic [NUM_CH*PRIO_W-1:0] chPrio,
  input logic                     xferDone,
  input logic [NUM_CH-1:0]        grantVec,
  input logic [IDX_W-1:0]         grantIdx,
  input logic                     grantValid,
  input logic [PRIO_W-1:0]        busPrio
);

  logic openWin;
  logic anyPart;
  assign openWin = !grantValid || xferDone;
  assign anyPart = |(chReq & chEn);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_clear_r1: assert (grantVec == '0 && !grantValid && busPrio == '0 && grantIdx == '0)
        else $error("reset state not clear");
    end
  end

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantVec) && (grantValid == (grantVec != '0)))
    else $error("grant vector malformed");

  p_idx_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grantValid |-> grantVec[grantIdx])
    else $error("index does not match vector");

  p_eval_fills_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (openWin && anyPart) |=> grantValid)
    else $error("participant present but no grant");

  p_empty_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (openWin && !anyPart) |=> (!grantValid && busPrio == '0))
    else $error("grant issued with no participant");

  p_no_preempt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (grantValid && !xferDone) |=> ($stable(grantVec) && $stable(busPrio) && $stable(grantIdx)))
    else $error("grant changed mid-transfer");

  for (genvar j = 0; j < NUM_CH; j++) begin : gChk
    p_only_elig_r2: assert property (@(posedge clk) disable iff (!rst_n)
      openWin |=> !(grantVec[j] && !$past(chReq[j] && chEn[j])))
      else $error("non-participant granted");

    p_top_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      openWin |=> !($past(chReq[j] && chEn[j]) && ($past(chPrio[j*PRIO_W +: PRIO_W]) > busPrio)))
      else $error("higher code overlooked");

    p_low_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
      openWin |=> !($past(chReq[j] && chEn[j]) && ($past(chPrio[j*PRIO_W +: PRIO_W]) == busPrio)
                    && (j < int'(grantIdx))))
      else $error("tie not given to lowest index");

    p_fwd_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (openWin && anyPart) |=> (!grantVec[j] || (busPrio == $past(chPrio[j*PRIO_W +: PRIO_W]))))
      else $error("forwarded code differs from winner code");
  end

endmodule

bind dma_chan_arbiter dma_chan_arbiter_chk #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chReq      (chReq),
  .chEn       (chEn),
  .chPrio     (chPrio),
  .xferDone   (xferDone),
  .grantVec   (grantVec),
  .grantIdx   (grantIdx),
  .grantValid (grantValid),
  .busPrio    (busPrio)
);

// File: tb/sim_dma_chan_arbiter.sv
module sim_dma_chan_arbiter;

  localparam int N  = 4;
  localparam int PW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  chReq = '0;
  logic [N-1:0]  chEn = '0;
  logic [N*PW-1:0] chPrio = '0;
  logic          xferDone = 1'b0;
  logic [N-1:0]  grantVec;
  logic [1:0]    grantIdx;
  logic          grantValid;
  logic [PW-1:0] busPrio;

  always #10 clk = ~clk;  // 50 MHz

  dma_chan_arbiter #(.NUM_CH(N), .PRIO_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .chReq(chReq), .chEn(chEn), .chPrio(chPrio),
    .xferDone(xferDone), .grantVec(grantVec), .grantIdx(grantIdx),
    .grantValid(grantValid), .busPrio(busPrio)
  );

  typedef struct {
    logic [N-1:0] vec;
    int           idx;
    int           prio;
    bit           valid;
    string        tag;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;

  // Reference state
  bit mValid = 0;
  int mIdx   = 0;
  int mPrio  = 0;

  // Monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      nChecks++;
      if (grantValid !== e.valid || grantVec !== e.vec ||
          int'(grantIdx) != e.idx || int'(busPrio) != e.prio) begin
        nFails++;
        $display("FAIL %s: got valid=%0b vec=%b idx=%0d prio=%0d, expected valid=%0b vec=%b idx=%0d prio=%0d",
                 e.tag, grantValid, grantVec, grantIdx, busPrio, e.valid, e.vec, e.idx, e.prio);
      end
    end
  end

  // Drive one cycle of inputs and queue the expected outcome
  task automatic step(input logic [N-1:0] rq, input logic [N-1:0] en,
                      input logic [N*PW-1:0] pr, input logic dn, input string tag);
    expItem_t e;
    @(negedge clk);
    chReq = rq; chEn = en; chPrio = pr; xferDone = dn;
    if (!mValid || dn) begin
      // search codes from the top down, channels from index 0 up
      mValid = 0; mIdx = 0; mPrio = 0;
      for (int p = (1 << PW) - 1; p >= 0 && !mValid; p--) begin
        for (int c = 0; c < N && !mValid; c++) begin
          if (rq[c] && en[c] && int'(pr[c*PW +: PW]) == p) begin
            mValid = 1; mIdx = c; mPrio = p;
          end
        end
      end
    end
    e.valid = mValid;
    e.vec   = mValid ? (N'(1) << mIdx) : '0;
    e.idx   = mIdx;
    e.prio  = mPrio;
    e.tag   = tag;
    @(posedge clk);
    #1 expQ.push_back(e);
  endtask

  function automatic logic [N*PW-1:0] pk(int p3, int p2, int p1, int p0);
    return {PW'(p3), PW'(p2), PW'(p1), PW'(p0)};
  endfunction

  task automatic finishRun();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    // R1: reset state
    repeat (2) @(negedge clk);
    nChecks++;
    if (grantValid !== 1'b0 || grantVec !== '0 || grantIdx !== '0 || busPrio !== '0) begin
      nFails++;
      $display("FAIL R1: got valid=%0b vec=%b idx=%0d prio=%0d, expected all zero",
               grantValid, grantVec, grantIdx, busPrio);
    end
    rst_n = 1'b1;

    step(4'b0000, 4'b1111, pk(3,3,3,3), 1'b0, "R8 idle none");
    step(4'b0100, 4'b1011, pk(0,3,0,0), 1'b0, "R2 req without enable");
    step(4'b0000, 4'b1111, pk(3,3,3,3), 1'b0, "R2 enable without req");
    step(4'b1010, 4'b1111, pk(2,0,1,0), 1'b0, "R3 code 10 over 01");
    step(4'b1011, 4'b1111, pk(2,0,1,3), 1'b0, "R7 hold vs higher newcomer");
    step(4'b0001, 4'b0001, pk(0,0,0,3), 1'b0, "R7 hold after requester leaves");
    step(4'b1011, 4'b1111, pk(2,0,1,3), 1'b1, "R5 done re-evaluates to code 11");
    step(4'b0110, 4'b1111, pk(0,3,3,0), 1'b1, "R4 tie 11 lowest index");
    step(4'b0111, 4'b1110, pk(0,3,3,3), 1'b1, "R4 tie with disabled ch0");
    step(4'b1111, 4'b1111, pk(0,0,0,0), 1'b1, "R4 all code 00");
    step(4'b1111, 4'b1111, pk(3,2,2,2), 1'b1, "R3 ch3 alone at 11");
    step(4'b0000, 4'b0000, pk(0,0,0,0), 1'b1, "R8 done with none");
    step(4'b0001, 4'b0001, pk(0,0,0,1), 1'b0, "R6 idle picks on next edge");

    // R3/R4/R5: every code combination, all channels participating
    for (int v = 0; v < 256; v++) begin
      step(4'b1111, 4'b1111, 8'(v), 1'b1, "R3 code sweep");
    end

    // R2/R3/R4/R7: pseudo-random patterns with random completion
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      logic [15:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr;
      step(a[3:0], a[7:4], a[15:8], a[0] ^ a[9], "R4 random mix");
    end

    finishRun();
  end

endmodule